// File: doc/BRIEF.md
# Sub-word memory lane access unit

This block sits between a load/store requester and a small row-organised data store. Each row holds a parameter-set number of bytes: eight for data storage, four for instruction storage. A request gives a byte address, an access size of 1, 2, 4 or 8 bytes, a write flag, a byte-reversal enable and, for writes, the data. The block splits the address into a row number and a byte position within the row. A read takes out the addressed lane. A write merges the new bytes into the stored row in the same cycle.

A request whose byte position is not a multiple of its size is rejected, and so is one wider than a row. The block pulses an error strobe for it and leaves the storage untouched. Lanes sit little-endian inside a row. The byte-reversal option flips byte order within the access width only: before the merge on a write, and after the extraction on a read. Read results are zero-extended to 64 bits and come back one cycle after the request with a one-cycle valid strobe.

Top module: `lane_access_unit`

## Requirements
- R1: After a synchronous reset, `rsp_valid` and `rsp_misalign` are low and every row reads as zero.
- R2: The row number is the address shifted right by log2(ROW_BYTES) and the byte position is the address AND (ROW_BYTES-1). Byte position k of a row occupies bits 8k+7 down to 8k.
- R3: `req_size` encodes the width as 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. A request is legal only when (byte position AND (width-1)) is zero and the width is no more than ROW_BYTES.
- R4: For an illegal request, `rsp_misalign` pulses high for exactly one cycle, one clock edge after the request. No row changes and `rsp_valid` stays low.
- R5: A legal read raises `rsp_valid` for one cycle, one edge after the request. `rsp_data` then holds the addressed bytes and is zero above the access width.
- R6: A legal write narrower than a row changes only the addressed bytes of that row. All other bytes keep their values.
- R7: With `req_swap` high, byte i of the access is exchanged with byte (width-1-i). This happens to the write data before it is merged, and to the read lane after it is extracted.
- R8: An access as wide as the row writes or returns the whole row.
- R9: A write never raises `rsp_valid`.
- R10: With four-byte rows, an 8-byte request is rejected as in R4, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width code (R3) |
| req_swap | input | 1 | Byte-reversal enable within the access width |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Read result valid strobe |
| rsp_data | output | 64 | Zero-extended read result |
| rsp_misalign | output | 1 | Rejected-request strobe |

## Verification
The bench sweeps every row, byte position, width and swap setting of a small eight-byte-row store. After each write it reads the whole row back, so bytes written outside their lane show up as a wrong neighbour byte, and a rejected write that still updated storage shows up as changed data. The sweep reads the same lane back with reversal on and off. This catches a reversal applied over the whole row rather than the access width, and one applied on the wrong side of the shift. The full-row and eight-byte cases expose a mask that loses the top lane. A four-byte-row instance checks that an access wider than the row is rejected rather than wrapped into the next row.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } lane_size_e;

    function automatic logic [31:0] size_bytes(lane_size_e s);
        return 32'd1 << s;
    endfunction

    function automatic logic [XLEN-1:0] lane_mask(lane_size_e s);
        logic [XLEN-1:0] m;
        case (s)
            SZ_1B:   m = 64'h0000_0000_0000_00FF;
            SZ_2B:   m = 64'h0000_0000_0000_FFFF;
            SZ_4B:   m = 64'h0000_0000_FFFF_FFFF;
            default: m = '1;
        endcase
        return m;
    endfunction

    // exchanges byte i with byte (n-1-i) inside the low n bytes
    function automatic logic [XLEN-1:0] reverse_bytes(logic [XLEN-1:0] d, lane_size_e s);
        logic [XLEN-1:0] r;
        int n;
        r = '0;
        n = int'(size_bytes(s));
        for (int i = 0; i < XLEN/8; i++) begin
            if (i < n) r[i*8 +: 8] = d[(n-1-i)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/lane_addr_split.sv
module lane_addr_split
    import lane_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    parameter int DEPTH = 16,
    localparam int OFF_W = $clog2(ROW_BYTES),
    localparam int RIDX_W = $clog2(DEPTH),
    localparam int ADDR_W = OFF_W + RIDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  lane_size_e        size,
    output logic [RIDX_W-1:0] row_idx,
    output logic [OFF_W-1:0]  offset,
    output logic              legal
);
    logic [31:0] nbytes;
    logic        fits;
    logic        aligned;

    always_comb begin
        offset  = addr[OFF_W-1:0];
        row_idx = addr[ADDR_W-1:OFF_W];
        nbytes  = size_bytes(size);
        fits    = nbytes <= 32'(ROW_BYTES);
        aligned = ((32'(offset) & (nbytes - 32'd1)) == 32'd0);
        legal   = fits && aligned;
    end
endmodule

// File: rtl/lane_extract.sv
module lane_extract
    import lane_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    localparam int OFF_W = $clog2(ROW_BYTES),
    localparam int ROW_W = ROW_BYTES * 8
) (
    input  logic [ROW_W-1:0] row,
    input  logic [OFF_W-1:0] offset,
    input  lane_size_e       size,
    input  logic             swap,
    output logic [XLEN-1:0]  data
);
    logic [XLEN-1:0]    wide;
    logic [XLEN-1:0]    lane;
    logic [OFF_W+2:0]   sh;
    logic               full;

    always_comb begin
        wide = XLEN'(row);
        sh   = {offset, 3'b000};
        full = size_bytes(size) == 32'(ROW_BYTES);
        if (full) lane = wide;
        else      lane = (wide & (lane_mask(size) << sh)) >> sh;
        data = swap ? reverse_bytes(lane, size) : lane;
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import lane_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    localparam int OFF_W = $clog2(ROW_BYTES),
    localparam int ROW_W = ROW_BYTES * 8
) (
    input  logic [ROW_W-1:0] row,
    input  logic [OFF_W-1:0] offset,
    input  lane_size_e       size,
    input  logic             swap,
    input  logic [XLEN-1:0]  wdata,
    output logic [ROW_W-1:0] new_row
);
    logic [XLEN-1:0]  src;
    logic [XLEN-1:0]  merged;
    logic [OFF_W+2:0] sh;
    logic             full;

    always_comb begin
        sh     = {offset, 3'b000};
        full   = size_bytes(size) == 32'(ROW_BYTES);
        src    = (swap ? reverse_bytes(wdata, size) : wdata) & lane_mask(size);
        merged = (XLEN'(row) & ~(lane_mask(size) << sh)) | (src << sh);
        new_row = full ? src[ROW_W-1:0] : merged[ROW_W-1:0];
    end
endmodule

// File: rtl/lane_access_unit.sv
module lane_access_unit
    import lane_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    parameter int DEPTH = 16,
    localparam int OFF_W = $clog2(ROW_BYTES),
    localparam int RIDX_W = $clog2(DEPTH),
    localparam int ADDR_W = OFF_W + RIDX_W,
    localparam int ROW_W = ROW_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_swap,
    input  logic [XLEN-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_data,
    output logic              rsp_misalign
);
    lane_size_e        size_e;
    logic [RIDX_W-1:0] row_idx;
    logic [OFF_W-1:0]  offset;
    logic              legal;
    logic [ROW_W-1:0]  cur_row;
    logic [ROW_W-1:0]  next_row;
    logic [XLEN-1:0]   load_data;
    logic              do_load;
    logic              do_store;
    logic [ROW_W-1:0]  rows_q [DEPTH];

    assign size_e   = lane_size_e'(req_size);
    assign cur_row  = rows_q[row_idx];
    assign do_load  = req_valid && !req_write && legal;
    assign do_store = req_valid && req_write && legal;

    lane_addr_split #(.ROW_BYTES(ROW_BYTES), .DEPTH(DEPTH)) u_split (
        .addr    (req_addr),
        .size    (size_e),
        .row_idx (row_idx),
        .offset  (offset),
        .legal   (legal)
    );

    lane_extract #(.ROW_BYTES(ROW_BYTES)) u_extract (
        .row    (cur_row),
        .offset (offset),
        .size   (size_e),
        .swap   (req_swap),
        .data   (load_data)
    );

    lane_merge #(.ROW_BYTES(ROW_BYTES)) u_merge (
        .row     (cur_row),
        .offset  (offset),
        .size    (size_e),
        .swap    (req_swap),
        .wdata   (req_wdata),
        .new_row (next_row)
    );

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst) rows_q[g] <= '0;
                else if (do_store && row_idx == RIDX_W'(g)) rows_q[g] <= next_row;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_misalign <= 1'b0;
            rsp_data     <= '0;
        end else begin
            rsp_valid    <= do_load;
            rsp_misalign <= req_valid && !legal;
            if (do_load) rsp_data <= load_data;
        end
    end

    // snapshot of the row a rejected write pointed at
    logic              chk_arm_q;
    logic [RIDX_W-1:0] chk_idx_q;
    logic [ROW_W-1:0]  chk_row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_arm_q <= 1'b0;
            chk_idx_q <= '0;
            chk_row_q <= '0;
        end else begin
            chk_arm_q <= req_valid && req_write && !legal;
            chk_idx_q <= row_idx;
            chk_row_q <= cur_row;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_misalign));

    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        chk_arm_q |-> rows_q[chk_idx_q] == chk_row_q);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_valid, rsp_misalign}));

    // R5
    rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R5
    rsp_width_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_data & ~lane_mask(lane_size_e'($past(req_size)))) == '0));

    // R9
    store_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_write) |-> !rsp_valid);

endmodule

// File: tb/test_lane_access_unit.sv
`timescale 1ns/1ps
module test_lane_access_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;

    // eight-byte rows, four rows
    logic        m_valid = 0, m_write = 0, m_swap = 0;
    logic [4:0]  m_addr = '0;
    logic [1:0]  m_size = '0;
    logic [63:0] m_wdata = '0;
    logic        m_rv, m_err;
    logic [63:0] m_rd;

    // four-byte rows, four rows
    logic        n_valid = 0, n_write = 0, n_swap = 0;
    logic [3:0]  n_addr = '0;
    logic [1:0]  n_size = '0;
    logic [63:0] n_wdata = '0;
    logic        n_rv, n_err;
    logic [63:0] n_rd;

    lane_access_unit #(.ROW_BYTES(8), .DEPTH(4)) i_lane_access_unit (
        .clk(clk), .rst(rst), .req_valid(m_valid), .req_write(m_write),
        .req_addr(m_addr), .req_size(m_size), .req_swap(m_swap),
        .req_wdata(m_wdata), .rsp_valid(m_rv), .rsp_data(m_rd),
        .rsp_misalign(m_err));

    lane_access_unit #(.ROW_BYTES(4), .DEPTH(4)) i_lane_access_unit_narrow (
        .clk(clk), .rst(rst), .req_valid(n_valid), .req_write(n_write),
        .req_addr(n_addr), .req_size(n_size), .req_swap(n_swap),
        .req_wdata(n_wdata), .rsp_valid(n_rv), .rsp_data(n_rd),
        .rsp_misalign(n_err));

    logic [7:0] ref_mem [32];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_req(input logic wr, input logic [4:0] a, input logic [1:0] sz,
                         input logic sw, input logic [63:0] wd,
                         output logic rv, output logic [63:0] rd, output logic er);
        @(negedge clk);
        m_valid = 1; m_write = wr; m_addr = a; m_size = sz; m_swap = sw; m_wdata = wd;
        @(negedge clk);
        m_valid = 0;
        rv = m_rv; rd = m_rd; er = m_err;
    endtask

    task automatic n_req(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                         input logic sw, input logic [63:0] wd,
                         output logic rv, output logic [63:0] rd, output logic er);
        @(negedge clk);
        n_valid = 1; n_write = wr; n_addr = a; n_size = sz; n_swap = sw; n_wdata = wd;
        @(negedge clk);
        n_valid = 0;
        rv = n_rv; rd = n_rd; er = n_err;
    endtask

    function automatic logic [63:0] exp_load(input int a, input int sz, input logic sw);
        logic [63:0] v, r;
        int n;
        n = 1 << sz;
        v = '0; r = '0;
        for (int i = 0; i < n; i++) v[i*8 +: 8] = ref_mem[a+i];
        if (!sw) return v;
        for (int i = 0; i < n; i++) r[i*8 +: 8] = v[(n-1-i)*8 +: 8];
        return r;
    endfunction

    task automatic model_store(input int a, input int sz, input logic sw, input logic [63:0] wd);
        int n;
        n = 1 << sz;
        for (int i = 0; i < n; i++)
            ref_mem[a+i] = sw ? wd[(n-1-i)*8 +: 8] : wd[i*8 +: 8];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic rv, er;
        logic [63:0] rd;
        int seq;
        seq = 0;
        for (int i = 0; i < 32; i++) ref_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: quiet strobes and empty rows
        chk("R1 rsp_valid after reset", {63'd0, m_rv}, 64'd0);
        chk("R1 rsp_misalign after reset", {63'd0, m_err}, 64'd0);
        for (int r = 0; r < 4; r++) begin
            m_req(0, 5'(r*8), 2'd3, 0, '0, rv, rd, er);
            chk("R1 row zero after reset", rd, 64'd0);
        end

        // R2: byte 3 of row 1 lands in bits 31:24
        m_req(1, 5'd11, 2'd0, 0, 64'hAB, rv, rd, er);
        model_store(11, 0, 0, 64'hAB);
        m_req(0, 5'd8, 2'd3, 0, '0, rv, rd, er);
        chk("R2 byte lane placement", rd, 64'h0000_0000_AB00_0000);

        // sweep: row, byte position, width, swap
        for (int r = 0; r < 4; r++)
          for (int o = 0; o < 8; o++)
            for (int s = 0; s < 4; s++)
              for (int w = 0; w < 2; w++) begin
                int a;
                logic leg;
                logic [63:0] wd;
                seq++;
                a = r*8 + o;
                leg = ((o & ((1 << s) - 1)) == 0);
                wd = 64'h0123_4567_89AB_CDEF ^ (64'(seq) * 64'h9E37_79B9_7F4A_7C15);
                m_req(1, 5'(a), 2'(s), w[0], wd, rv, rd, er);
                chk("R3 R4 store reject flag", {63'd0, er}, {63'd0, !leg});
                chk("R9 store gives no rsp_valid", {63'd0, rv}, 64'd0);
                if (leg) model_store(a, s, w[0], wd);
                m_req(0, 5'(r*8), 2'd3, 0, '0, rv, rd, er);
                chk("R6 R8 R4 full row after store", rd, exp_load(r*8, 3, 0));
                m_req(0, 5'(a), 2'(s), w[0], '0, rv, rd, er);
                chk("R5 load valid strobe", {63'd0, rv}, {63'd0, leg});
                chk("R4 load reject flag", {63'd0, er}, {63'd0, !leg});
                if (leg) begin
                    if (w == 1) chk("R7 swapped load data", rd, exp_load(a, s, 1));
                    else        chk("R5 load data", rd, exp_load(a, s, 0));
                end
              end

        // R5: strobe lasts one cycle
        m_req(0, 5'd0, 2'd0, 0, '0, rv, rd, er);
        @(negedge clk);
        chk("R5 strobe one cycle", {63'd0, m_rv}, 64'd0);

        // narrow rows
        n_req(1, 4'd4, 2'd2, 0, 64'h1122_3344, rv, rd, er);
        chk("R8 narrow full row store accepted", {63'd0, er}, 64'd0);
        n_req(0, 4'd4, 2'd2, 0, '0, rv, rd, er);
        chk("R8 narrow full row load", rd, 64'h1122_3344);
        n_req(0, 4'd6, 2'd1, 0, '0, rv, rd, er);
        chk("R2 narrow upper half", rd, 64'h1122);
        n_req(0, 4'd6, 2'd1, 1, '0, rv, rd, er);
        chk("R7 narrow swapped half", rd, 64'h2211);
        n_req(0, 4'd7, 2'd0, 0, '0, rv, rd, er);
        chk("R2 narrow top byte", rd, 64'h11);
        for (int a = 0; a < 16; a += 4) begin
            n_req(1, 4'(a), 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, rv, rd, er);
            chk("R10 wide store rejected", {63'd0, er}, 64'd1);
            n_req(0, 4'(a), 2'd3, 0, '0, rv, rd, er);
            chk("R10 wide load rejected", {62'd0, rv, er}, 64'd1);
        end
        n_req(0, 4'd4, 2'd2, 0, '0, rv, rd, er);
        chk("R10 row kept after wide store", rd, 64'h1122_3344);
        n_req(0, 4'd0, 2'd2, 0, '0, rv, rd, er);
        chk("R10 row 0 kept after wide store", rd, 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule